// File: doc/BRIEF.md
# Dual-Clock Sequential Field Memory

This block is a sequential-access line or field store with a write port and a read port. Each port runs on its own clock. Each port has its own address counter. A counter only moves forward and wraps from the last location back to zero. A synchronous pointer-clear input on each port returns that counter to zero.

There are no full or empty flags. The write side overwrites older data in order, and the read side walks the same array at its own pace. Whether a read sees the current write series or the one before it depends only on how far the read address trails the write address.

The write port has two controls:
- A write enable decides whether a write cycle advances the address.
- An input enable decides whether the word is actually stored during that cycle. This lets a field be skipped over without changing it.

The read port has two controls:
- A read enable decides whether a read cycle fetches a word and advances the address.
- An output enable forces the data output to zero while it is low.

Storage is an inferred two-clock dual-port RAM with a registered read.

Top module: `field_mem`

## Requirements
- R1: While `rst_ni` is low, and after it is released with no read performed, `rdata_o` is zero when `oe_i` is high.
- R2: A write-clock edge with `wrst_i` high stores nothing, even when `we_i` and `ie_i` are high. The next write cycle uses address 0, and the cycles after it use addresses 1, 2 and so on.
- R3: A read-clock edge with `rrst_i` high leaves `rdata_o` unchanged. The next read cycle returns the word at address 0, and the cycles after it return addresses 1, 2 and so on.
- R4: A write-clock edge with `we_i` low stores nothing and does not move the write address.
- R5: A write-clock edge with `we_i` high and `ie_i` low moves the write address forward by one and leaves the addressed word unchanged.
- R6: A read-clock edge with `re_i` low keeps the read address and keeps `rdata_o` at its last value.
- R7: While `oe_i` is low, `rdata_o` is zero. Output enable has no effect on the read address or on the registered word, which reappears when `oe_i` returns high.
- R8: Both address counters wrap from DEPTH-1 to 0 without any reset.
- R9: After a write reset, reads of addresses already rewritten in the current series return the new words. Reads of addresses beyond the write address return the words of the previous series.
- R10: Read data is registered. The word for an address shows on `rdata_o` just after the read-clock edge of the cycle that uses that address, and stays there until the next read cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Asynchronous active-low reset of both counters and the read register |
| wclk_i | input | 1 | Write clock |
| wrst_i | input | 1 | Write pointer clear, synchronous to `wclk_i` |
| we_i | input | 1 | Write enable; low makes a disable cycle |
| ie_i | input | 1 | Input enable; low skips storage but still advances |
| wdata_i | input | WIDTH | Write data word |
| rclk_i | input | 1 | Read clock |
| rrst_i | input | 1 | Read pointer clear, synchronous to `rclk_i` |
| re_i | input | 1 | Read enable |
| oe_i | input | 1 | Output enable; low forces the output to zero |
| rdata_o | output | WIDTH | Registered read data word |

## Verification
The bench uses a 16-word, 8-bit configuration. Every location is written with a series-dependent arithmetic pattern, and each series is read back in full. This separates correct address order from stuck or skipped counters. A second full pass without any pointer clear exercises wrapping on both sides. A partial series written after a write reset, then read end to end, shows the boundary where new data changes to previous-series data. Runs of disable cycles, input-skip cycles, held reads and output-enable toggles are each followed by reads of the neighbouring addresses. These reads show whether a control moved a pointer or touched the array when it should not have.

// File: rtl/field_mem_pkg.sv
package field_mem_pkg;
  localparam int unsigned DEF_DEPTH = 1024;
  localparam int unsigned DEF_WIDTH = 12;

  typedef enum logic [1:0] {
    WR_HOLD  = 2'd0,
    WR_SKIP  = 2'd1,
    WR_STORE = 2'd2,
    WR_CLEAR = 2'd3
  } wr_op_e;
endpackage

// File: rtl/field_mem_ptr.sv
module field_mem_ptr #(
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          adv_i,
  output logic [AW-1:0] ptr_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ptr_q <= '0;
    else if (clr_i)     ptr_q <= '0;
    else if (adv_i)     ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/field_mem_wr_dec.sv
module field_mem_wr_dec
  import field_mem_pkg::*;
(
  input  logic wrst_i,
  input  logic we_i,
  input  logic ie_i,
  output logic clr_o,
  output logic adv_o,
  output logic store_o
);
  wr_op_e op;

  always_comb begin
    if (wrst_i)     op = WR_CLEAR;
    else if (!we_i) op = WR_HOLD;
    else if (!ie_i) op = WR_SKIP;
    else            op = WR_STORE;
  end

  assign clr_o   = (op == WR_CLEAR);
  assign adv_o   = (op == WR_SKIP) || (op == WR_STORE);
  assign store_o = (op == WR_STORE);
endmodule

// File: rtl/field_mem_ram.sv
module field_mem_ram #(
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned WIDTH = 12,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic             wclk_i,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             rclk_i,
  input  logic             rst_ni,
  input  logic             re_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [WIDTH-1:0] q;

  always_ff @(posedge wclk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni)   q <= '0;
    else if (re_i) q <= mem[raddr_i];
  end

  assign rdata_o = q;
endmodule

// File: rtl/field_mem.sv
module field_mem
  import field_mem_pkg::*;
#(
  parameter int unsigned DEPTH = DEF_DEPTH,
  parameter int unsigned WIDTH = DEF_WIDTH,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic             rst_ni,
  input  logic             wclk_i,
  input  logic             wrst_i,
  input  logic             we_i,
  input  logic             ie_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             rclk_i,
  input  logic             rrst_i,
  input  logic             re_i,
  input  logic             oe_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic          w_clr, w_adv, w_store;
  logic          r_adv;
  logic [AW-1:0] waddr, raddr;
  logic [WIDTH-1:0] ram_q;

  field_mem_wr_dec u_wr_dec (
    .wrst_i (wrst_i),
    .we_i   (we_i),
    .ie_i   (ie_i),
    .clr_o  (w_clr),
    .adv_o  (w_adv),
    .store_o(w_store)
  );

  field_mem_ptr #(.DEPTH(DEPTH), .AW(AW)) u_wptr (
    .clk_i (wclk_i),
    .rst_ni(rst_ni),
    .clr_i (w_clr),
    .adv_i (w_adv),
    .ptr_o (waddr)
  );

  // reset cycle never fetches
  assign r_adv = re_i & ~rrst_i;

  field_mem_ptr #(.DEPTH(DEPTH), .AW(AW)) u_rptr (
    .clk_i (rclk_i),
    .rst_ni(rst_ni),
    .clr_i (rrst_i),
    .adv_i (r_adv),
    .ptr_o (raddr)
  );

  field_mem_ram #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) u_ram (
    .wclk_i (wclk_i),
    .we_i   (w_store),
    .waddr_i(waddr),
    .wdata_i(wdata_i),
    .rclk_i (rclk_i),
    .rst_ni (rst_ni),
    .re_i   (r_adv),
    .raddr_i(raddr),
    .rdata_o(ram_q)
  );

  assign rdata_o = oe_i ? ram_q : '0;
endmodule

// File: rtl/field_mem_chk.sv
module field_mem_chk #(
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned WIDTH = 12,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input logic             rst_ni,
  input logic             wclk_i,
  input logic             wrst_i,
  input logic             we_i,
  input logic             rclk_i,
  input logic             rrst_i,
  input logic             re_i,
  input logic [AW-1:0]    waddr,
  input logic [AW-1:0]    raddr,
  input logic [WIDTH-1:0] ram_q
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  // R2
  wptr_clear_chk: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    wrst_i |=> waddr == '0);

  // R4
  wptr_hold_chk: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (!wrst_i && !we_i) |=> $stable(waddr));

  // R5
  wptr_step_chk: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (!wrst_i && we_i && waddr != LAST) |=> waddr == $past(waddr) + 1'b1);

  // R8
  wptr_wrap_chk: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (!wrst_i && we_i && waddr == LAST) |=> waddr == '0);

  // R3
  rptr_clear_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    rrst_i |=> (raddr == '0) && $stable(ram_q));

  // R6
  rptr_hold_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (!rrst_i && !re_i) |=> $stable(raddr) && $stable(ram_q));

  // R8
  rptr_wrap_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (!rrst_i && re_i && raddr == LAST) |=> raddr == '0);
endmodule

bind field_mem field_mem_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) u_chk (
  .rst_ni(rst_ni),
  .wclk_i(wclk_i),
  .wrst_i(wrst_i),
  .we_i  (we_i),
  .rclk_i(rclk_i),
  .rrst_i(rrst_i),
  .re_i  (re_i),
  .waddr (waddr),
  .raddr (raddr),
  .ram_q (ram_q)
);

// File: tb/field_mem_bench.sv
module field_mem_bench;
  localparam int DEPTH = 16;
  localparam int WIDTH = 8;

  logic rst_n = 1'b0;
  logic wclk = 1'b0, rclk = 1'b0;
  logic wrst = 1'b0, we = 1'b0, ie = 1'b0;
  logic rrst = 1'b0, re = 1'b0, oe = 1'b1;
  logic [WIDTH-1:0] wdata = '0;
  logic [WIDTH-1:0] rdata;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  logic [WIDTH-1:0] m_mem [DEPTH];
  int m_wp = 0, m_rp = 0;
  logic [WIDTH-1:0] m_q = '0;

  field_mem #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_field_mem (
    .rst_ni (rst_n),
    .wclk_i (wclk),
    .wrst_i (wrst),
    .we_i   (we),
    .ie_i   (ie),
    .wdata_i(wdata),
    .rclk_i (rclk),
    .rrst_i (rrst),
    .re_i   (re),
    .oe_i   (oe),
    .rdata_o(rdata)
  );

  always #4 wclk = ~wclk;
  initial begin
    #1;
    forever #4 rclk = ~rclk;
  end

  function automatic logic [WIDTH-1:0] pat(int s, int a);
    return WIDTH'((s * 37 + a * 11 + 3) % 256);
  endfunction

  task automatic check(logic [WIDTH-1:0] act, logic [WIDTH-1:0] exp, string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(bit r, bit e, bit i, logic [WIDTH-1:0] d);
    @(negedge wclk);
    wrst = r; we = e; ie = i; wdata = d;
    @(posedge wclk);
    if (r) m_wp = 0;
    else if (e) begin
      if (i) m_mem[m_wp] = d;
      m_wp = (m_wp + 1) % DEPTH;
    end
    #1;
    wrst = 1'b0; we = 1'b0; ie = 1'b0;
  endtask

  task automatic rd(bit r, bit e, string tag);
    @(negedge rclk);
    rrst = r; re = e;
    @(posedge rclk);
    if (r) m_rp = 0;
    else if (e) begin
      m_q = m_mem[m_rp];
      m_rp = (m_rp + 1) % DEPTH;
    end
    #2;
    check(rdata, oe ? m_q : '0, tag);
    rrst = 1'b0; re = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    #10;
    check(rdata, '0, "R1 in reset");
    rst_n = 1'b1;
    rd(0, 0, "R1 after release");

    // R2 R3 R10: full series 1
    wr(1, 1, 1, 8'hEE);
    for (int a = 0; a < DEPTH; a++) wr(0, 1, 1, pat(1, a));
    rd(1, 0, "R3 reset cycle holds output");
    for (int a = 0; a < DEPTH; a++) rd(0, 1, "R10 R2 series1 read");

    // R8: wrap both pointers without reset
    for (int a = 0; a < DEPTH; a++) wr(0, 1, 1, pat(2, a));
    for (int a = 0; a < DEPTH; a++) rd(0, 1, "R8 wrapped read");

    // R9: partial series 3 after write reset
    wr(1, 0, 0, '0);
    for (int a = 0; a < 6; a++) wr(0, 1, 1, pat(3, a));
    rd(1, 0, "R3 read reset");
    for (int a = 0; a < DEPTH; a++) rd(0, 1, a < 6 ? "R9 new data" : "R9 old data");

    // R4: disable cycles store nothing and hold address
    wr(1, 0, 0, '0);
    for (int k = 0; k < 3; k++) wr(0, 0, 1, 8'h5A);
    wr(0, 1, 1, pat(4, 0));
    for (int k = 0; k < 2; k++) wr(0, 0, 1, 8'hA5);
    rd(1, 0, "R3 read reset");
    rd(0, 1, "R4 addr0 after disables");
    rd(0, 1, "R4 addr1 untouched");

    // R2 + R5: reset cycle with we/ie high stores nothing; skip cycles advance
    wr(1, 1, 1, 8'hC3);
    wr(0, 1, 0, 8'h11);
    wr(0, 1, 0, 8'h22);
    wr(0, 1, 1, pat(5, 2));
    rd(1, 0, "R3 read reset");
    rd(0, 1, "R2 reset cycle stored nothing");
    rd(0, 1, "R5 skipped word kept");
    rd(0, 1, "R5 addr2 written after skips");

    // R6: held reads
    rd(1, 0, "R3 read reset");
    rd(0, 1, "R6 first read");
    for (int k = 0; k < 3; k++) rd(0, 0, "R6 held output");
    rd(0, 1, "R6 address held");

    // R7: output enable
    @(negedge rclk);
    oe = 1'b0;
    #1;
    check(rdata, '0, "R7 oe low forces zero");
    oe = 1'b1;
    #1;
    check(rdata, m_q, "R7 word restored");
    oe = 1'b0;
    rd(0, 1, "R7 read with oe low");
    oe = 1'b1;
    #1;
    check(rdata, m_q, "R7 read during oe low advanced");
    rd(0, 1, "R7 next address");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule